// File: doc/BRIEF.md
# Pulse Board Control and Status Registers

This block is the register bank of a six-channel pulse board. It sits on a plain synchronous register bus (address, write data, write strobe, read strobe, registered read data). Read-only registers report the on-board switch bank, whether a timing-network module is fitted, and the hardware and firmware versions. Sticky error flags catch single-cycle event pulses from elsewhere on the board and hold them until software writes 1 to them. These flags cover two I2C faults and, per channel, a frequency-limit fault and a frequency-watchdog fault.

A guarded reset register lets software request a logic reset. The request fires only when an unlock bit was already set by an earlier write. The guard is a three-state machine. In `LOCKED`, a control write with the unlock bit at 1 moves to `ARMED`, and a command bit in that write is ignored. In `ARMED`, a control write with the command bit at 1 moves to `FIRING`. A control write with unlock at 0 and no command returns to `LOCKED`. `FIRING` lasts exactly one cycle and drives the reset request. It then returns to `LOCKED`, or to `ARMED` if that same cycle holds a control write with unlock at 1. The unlock bit reads back as 1 only in `ARMED`.

Register map (addresses in hex, unlisted bits read 0):

| Addr | Contents |
|---|---|
| 0 | [7:0] firmware version byte, [13:8] hardware version |
| 1 | [7:0] switches, [8] timing-network present |
| 2 | [0] I2C timeout flag, [1] I2C bad-address flag (W1C) |
| 3 | [5:0] frequency-limit flags (W1C) |
| 4 | [5:0] frequency-watchdog flags (W1C) |
| 5 | [0] unlock (read/write), [1] reset command (write-only, reads 0) |

Top module: `pcr_status_regs`

## Requirements
- R1: Address 1 reads the switch bank in bits [7:0], with bank 1 switches 1..4 in bits 0..3 and bank 2 switches 1..4 in bits 4..7. A switch that is ON reads 1. Bit 8 reads 1 when the timing-network module is present.
- R2: Address 0 reads the firmware version byte in bits [7:0], with the major release in the upper nibble and the minor release in the lower nibble. It reads the 6-bit hardware version input in bits [13:8]. All other bits read 0.
- R3: All sticky flags and the unlock bit are 0 after reset. A one-cycle event pulse sets its flag, and the flag stays 1 until a write-1 clear removes it.
- R4: A write to a flag register clears exactly the bits written as 1. Bits written as 0 keep their value. For the per-channel vectors at addresses 3 and 4, bit 0 is channel 1 and bit 5 is channel 6.
- R5: When a set event and a write-1 clear reach the same flag bit in the same cycle, the flag ends at 1.
- R6: Address 2 bit 0 is the I2C watchdog-timeout flag and bit 1 is the I2C bad-address flag.
- R7: Address 5 bit 0 is an unlock bit that reads back what was last written. Writing 0 to it while unlocked locks the guard again.
- R8: A write to address 5 with bit 1 set, while the unlock bit already reads 1, gives exactly one cycle of `logic_rst_req` in the cycle after the write. It also clears the unlock bit.
- R9: A write to address 5 with bit 1 set while the unlock bit reads 0 gives no reset request. This holds even when that same write sets the unlock bit.
- R10: A read of an unmapped address (6 to 15) returns 0 and changes no register.
- R11: `rdata` takes the addressed value on the clock edge that samples `rd_en` and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| sw_in | input | 8 | Switch bank levels, 1 = ON |
| tnet_present | input | 1 | Timing-network module fitted |
| hw_ver | input | 6 | Board hardware version |
| i2c_tmo_ev | input | 1 | I2C watchdog timeout event pulse |
| i2c_badaddr_ev | input | 1 | I2C non-existent address event pulse |
| flim_ev | input | 6 | Per-channel frequency-limit event pulses |
| fwdg_ev | input | 6 | Per-channel frequency-watchdog event pulses |
| logic_rst_req | output | 1 | One-cycle logic reset request |

## Verification
Two functions can hit the same flag bit in one cycle: a set event from the board and a software write-1 clear. The bench drives an event pulse and a bus write to the same register in one cycle. It clears some bits that are being set again and some that are not, then reads the register back and expects every re-set bit at 1 and every other written bit at 0. The same collision is provoked on the I2C flags. The reset guard gets a similar treatment: one write that both sets unlock and issues the command must not fire.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_VERSION = 4'h0;
    localparam logic [ADDR_W-1:0] A_BOARD   = 4'h1;
    localparam logic [ADDR_W-1:0] A_I2C     = 4'h2;
    localparam logic [ADDR_W-1:0] A_FLIM    = 4'h3;
    localparam logic [ADDR_W-1:0] A_FWDG    = 4'h4;
    localparam logic [ADDR_W-1:0] A_RSTCTL  = 4'h5;

    localparam int CTL_UNLOCK_BIT = 0;
    localparam int CTL_CMD_BIT    = 1;

    typedef enum logic [1:0] {
        GUARD_LOCKED = 2'd0,
        GUARD_ARMED  = 2'd1,
        GUARD_FIRING = 2'd2
    } guard_state_t;

endpackage

// File: rtl/pcr_sticky_bank.sv
module pcr_sticky_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] clr_eff;

    assign clr_eff = clr_wr_i ? clr_mask_i : '0;

    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_o[i] <= 1'b0;
            else if (set_i[i])
                flags_o[i] <= 1'b1;
            else if (clr_eff[i])
                flags_o[i] <= 1'b0;
        end
    end

    // R5: a set pulse always leaves its bit at 1, clear or not
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R3: no bit rises without an event
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));

    // R4: without a clear write, every set bit holds
    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

endmodule

// File: rtl/pcr_reset_guard.sv
module pcr_reset_guard
    import pcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic wr_unlock_i,
    input  logic wr_cmd_i,
    output logic unlock_o,
    output logic rst_req_o
);

    guard_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= GUARD_LOCKED;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            GUARD_LOCKED: begin
                if (ctrl_wr_i && wr_unlock_i)
                    state_nx = GUARD_ARMED;
            end
            GUARD_ARMED: begin
                if (ctrl_wr_i) begin
                    if (wr_cmd_i)
                        state_nx = GUARD_FIRING;
                    else if (!wr_unlock_i)
                        state_nx = GUARD_LOCKED;
                end
            end
            GUARD_FIRING: begin
                if (ctrl_wr_i && wr_unlock_i)
                    state_nx = GUARD_ARMED;
                else
                    state_nx = GUARD_LOCKED;
            end
            default: state_nx = GUARD_LOCKED;
        endcase
    end

    always_comb begin
        unlock_o  = 1'b0;
        rst_req_o = 1'b0;
        unique case (state)
            GUARD_LOCKED: ;
            GUARD_ARMED:  unlock_o  = 1'b1;
            GUARD_FIRING: rst_req_o = 1'b1;
            default: ;
        endcase
    end

    // R8: a request is a single cycle
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R8: a request needs a prior unlock and a command write
    p_req_needs_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(unlock_o) && $past(ctrl_wr_i && wr_cmd_i)));

    // R8: unlock is gone while the request is out
    p_unlock_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !unlock_o);

    // R9: a command while locked never fires
    p_locked_no_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock_o && ctrl_wr_i && wr_cmd_i) |=> !rst_req_o);

endmodule

// File: rtl/pcr_read_mux.sv
module pcr_read_mux
    import pcr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int NUM_SW = 8,
    parameter int HW_W   = 6,
    parameter int FW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FW_W-1:0]   fw_byte,
    input  logic [HW_W-1:0]   hw_ver,
    input  logic [NUM_SW-1:0] sw_in,
    input  logic              tnet_present,
    input  logic [1:0]        i2c_flags,
    input  logic [NUM_CH-1:0] flim_flags,
    input  logic [NUM_CH-1:0] fwdg_flags,
    input  logic              unlock,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;
    logic              mapped;

    always_comb begin
        sel    = '0;
        mapped = 1'b1;
        unique case (addr)
            A_VERSION: begin
                sel[FW_W-1:0]           = fw_byte;
                sel[FW_W+HW_W-1:FW_W]   = hw_ver;
            end
            A_BOARD: begin
                sel[NUM_SW-1:0] = sw_in;
                sel[NUM_SW]     = tnet_present;
            end
            A_I2C:    sel[1:0]        = i2c_flags;
            A_FLIM:   sel[NUM_CH-1:0] = flim_flags;
            A_FWDG:   sel[NUM_CH-1:0] = fwdg_flags;
            A_RSTCTL: sel[CTL_UNLOCK_BIT] = unlock;
            default:  mapped = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= sel;
    end

    // R10: unmapped reads return zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0));

    // R11: rdata holds between reads
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/pcr_status_regs.sv
module pcr_status_regs
    import pcr_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int NUM_SW   = 8,
    parameter int HW_W     = 6,
    parameter int FW_MAJOR = 2,
    parameter int FW_MINOR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_SW-1:0] sw_in,
    input  logic              tnet_present,
    input  logic [HW_W-1:0]   hw_ver,
    input  logic              i2c_tmo_ev,
    input  logic              i2c_badaddr_ev,
    input  logic [NUM_CH-1:0] flim_ev,
    input  logic [NUM_CH-1:0] fwdg_ev,
    output logic              logic_rst_req
);

    localparam int          FW_W    = 8;
    localparam logic [3:0]  FW_HI   = 4'(FW_MAJOR);
    localparam logic [3:0]  FW_LO   = 4'(FW_MINOR);
    localparam logic [FW_W-1:0] FW_BYTE = {FW_HI, FW_LO};

    logic wr_i2c, wr_flim, wr_fwdg, wr_ctl;
    logic [1:0]        i2c_flags;
    logic [NUM_CH-1:0] flim_flags;
    logic [NUM_CH-1:0] fwdg_flags;
    logic              unlock;
    logic              unused_wbits;

    assign wr_i2c  = wr_en && (addr == A_I2C);
    assign wr_flim = wr_en && (addr == A_FLIM);
    assign wr_fwdg = wr_en && (addr == A_FWDG);
    assign wr_ctl  = wr_en && (addr == A_RSTCTL);
    assign unused_wbits = ^wdata[DATA_W-1:NUM_CH];

    pcr_sticky_bank #(.W(2)) i_i2c_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     ({i2c_badaddr_ev, i2c_tmo_ev}),
        .clr_wr_i  (wr_i2c),
        .clr_mask_i(wdata[1:0]),
        .flags_o   (i2c_flags)
    );

    pcr_sticky_bank #(.W(NUM_CH)) i_flim_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (flim_ev),
        .clr_wr_i  (wr_flim),
        .clr_mask_i(wdata[NUM_CH-1:0]),
        .flags_o   (flim_flags)
    );

    pcr_sticky_bank #(.W(NUM_CH)) i_fwdg_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (fwdg_ev),
        .clr_wr_i  (wr_fwdg),
        .clr_mask_i(wdata[NUM_CH-1:0]),
        .flags_o   (fwdg_flags)
    );

    pcr_reset_guard i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (wr_ctl),
        .wr_unlock_i(wdata[CTL_UNLOCK_BIT]),
        .wr_cmd_i   (wdata[CTL_CMD_BIT]),
        .unlock_o   (unlock),
        .rst_req_o  (logic_rst_req)
    );

    pcr_read_mux #(
        .NUM_CH(NUM_CH),
        .NUM_SW(NUM_SW),
        .HW_W  (HW_W),
        .FW_W  (FW_W)
    ) i_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .addr        (addr),
        .fw_byte     (FW_BYTE),
        .hw_ver      (hw_ver),
        .sw_in       (sw_in),
        .tnet_present(tnet_present),
        .i2c_flags   (i2c_flags),
        .flim_flags  (flim_flags),
        .fwdg_flags  (fwdg_flags),
        .unlock      (unlock),
        .rdata       (rdata)
    );

    // R6: I2C timeout event lands on bit 0 of its register
    p_i2c_tmo_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_tmo_ev |=> i2c_flags[0]);

    // R9: unlock rises only from a control write
    p_unlock_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(wr_ctl));

endmodule

// File: tb/test_pcr_status_regs.sv
`timescale 1ns/1ps
module test_pcr_status_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic [7:0]  sw_in = '0;
    logic        tnet_present = 1'b0;
    logic [5:0]  hw_ver = 6'h11;
    logic        i2c_tmo_ev = 1'b0;
    logic        i2c_badaddr_ev = 1'b0;
    logic [5:0]  flim_ev = '0;
    logic [5:0]  fwdg_ev = '0;
    logic        logic_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #4 clk = ~clk;

    pcr_status_regs i_pcr_status_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .sw_in(sw_in),
        .tnet_present(tnet_present), .hw_ver(hw_ver),
        .i2c_tmo_ev(i2c_tmo_ev), .i2c_badaddr_ev(i2c_badaddr_ev),
        .flim_ev(flim_ev), .fwdg_ev(fwdg_ev), .logic_rst_req(logic_rst_req)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard after each sampled read
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    check("scoreboard underflow", 16'h0, 16'h1);
                end else begin
                    rd_item_t it;
                    it = sb.pop_front();
                    check(it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        sb.push_back('{exp, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R3 reset rst_req", {15'd0, logic_rst_req}, 16'h0);
        check("R11 reset rdata", rdata, 16'h0);

        // version: fw 2.3, hw 0b010001
        rd(4'h0, 16'h1123, "R2 version register");
        sw_in = 8'hA5; tnet_present = 1'b1;
        rd(4'h1, 16'h01A5, "R1 switches A5 present");
        sw_in = 8'h0F; tnet_present = 1'b0;
        rd(4'h1, 16'h000F, "R1 switches 0F absent");

        rd(4'h2, 16'h0, "R3 reset i2c flags");
        rd(4'h3, 16'h0, "R3 reset flim flags");
        rd(4'h4, 16'h0, "R3 reset fwdg flags");
        rd(4'h5, 16'h0, "R3 reset unlock");

        // flim events ch1 and ch6
        @(negedge clk); flim_ev = 6'b100001;
        @(negedge clk); flim_ev = '0;
        rd(4'h3, 16'h0021, "R3 flim set");
        idle(5);
        rd(4'h3, 16'h0021, "R3 flim sticky");
        wr(4'h3, 16'h0001);
        rd(4'h3, 16'h0020, "R4 clear ch1 only");
        wr(4'h3, 16'h0000);
        rd(4'h3, 16'h0020, "R4 write zero keeps");

        // fwdg and i2c
        @(negedge clk); fwdg_ev = 6'b000110; i2c_tmo_ev = 1'b1;
        @(negedge clk); fwdg_ev = '0; i2c_tmo_ev = 1'b0;
        rd(4'h2, 16'h0001, "R6 timeout on bit0");
        @(negedge clk); i2c_badaddr_ev = 1'b1;
        @(negedge clk); i2c_badaddr_ev = 1'b0;
        rd(4'h2, 16'h0003, "R6 bad address on bit1");
        rd(4'h4, 16'h0006, "R3 fwdg set");

        // collision: set and clear in the same cycle
        @(negedge clk);
        addr = 4'h4; wdata = 16'h0006; wr_en = 1'b1; fwdg_ev = 6'b000010;
        @(negedge clk);
        wr_en = 1'b0; fwdg_ev = '0;
        rd(4'h4, 16'h0002, "R5 fwdg set wins");
        @(negedge clk);
        addr = 4'h2; wdata = 16'h0003; wr_en = 1'b1; i2c_tmo_ev = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; i2c_tmo_ev = 1'b0;
        rd(4'h2, 16'h0001, "R5 i2c set wins");

        // unmapped
        rd(4'h9, 16'h0, "R10 unmapped reads zero");
        rd(4'hF, 16'h0, "R10 top address zero");
        rd(4'h3, 16'h0020, "R10 flim unchanged");
        rd(4'h2, 16'h0001, "R10 i2c unchanged");

        // reset guard
        wr(4'h5, 16'h0002);
        check("R9 locked command no pulse", {15'd0, logic_rst_req}, 16'h0);
        idle(1);
        check("R9 locked command no pulse later", {15'd0, logic_rst_req}, 16'h0);
        wr(4'h5, 16'h0003);
        check("R9 combined write no pulse", {15'd0, logic_rst_req}, 16'h0);
        rd(4'h5, 16'h0001, "R7 unlock reads back");
        wr(4'h5, 16'h0002);
        check("R8 pulse after armed command", {15'd0, logic_rst_req}, 16'h1);
        idle(1);
        check("R8 pulse one cycle", {15'd0, logic_rst_req}, 16'h0);
        rd(4'h5, 16'h0000, "R8 unlock cleared");
        wr(4'h5, 16'h0001);
        wr(4'h5, 16'h0000);
        rd(4'h5, 16'h0000, "R7 relock by write zero");
        wr(4'h5, 16'h0002);
        check("R7 relocked command ignored", {15'd0, logic_rst_req}, 16'h0);

        // hold between reads
        sw_in = 8'h3C; tnet_present = 1'b1;
        rd(4'h1, 16'h013C, "R1 switches 3C present");
        sw_in = 8'hFF;
        idle(3);
        check("R11 rdata held", rdata, 16'h013C);

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule